// File: doc/BRIEF.md
# Grouped Power-Up and Initialization Sequencer

This block brings a bank of sixteen echo-canceller groups out of power-down. Each group serves a pair of channels (A and B). An active-low reset input holds the whole bank in a power-down state. In that state the output enable is low, so the host data bus and the serial outputs float, and every group's power-up flag is cleared. When reset is released, the block checks how long reset was held low. A pulse that was too short leaves the block refusing access and raises an invalid-reset flag. A pulse that was long enough starts a fixed clock-lock wait. Register access is granted only when that wait has expired.

Once access is granted, the host sets or clears one group's power-up flag per write. A 0-to-1 change on a flag starts an initialization pass for that group. During the pass the group is busy and its coefficient-clear line is high. A shared write port loads the group's 64-entry register window with default values, and the window is written once for both channels. The pass ends on the second frame sync pulse after the write. After that the group reports ready, and the host may write its per-channel registers. Clearing the flag during a pass aborts the pass and puts the group back into power-down.

Top module: `grp_pwr_seq`

## Requirements
- R1: While `rst_n` is low, the next edge drives `out_en_o`, `acc_ok_o`, `init_we_o` and every bit of `pwup_o`, `busy_o`, `ready_o` and `coef_clr_o` to 0. This holds even if groups were powered before.
- R2: Suppose `rst_n` was sampled low on at least HOLD_CYC consecutive edges. Count the edge that first samples it high as edge 0. Then `acc_ok_o` rises after edge LOCK_CYC and not before.
- R3: Suppose `rst_n` was sampled low on fewer than HOLD_CYC edges. Then after its release `rst_bad_o` is 1, and `acc_ok_o` stays 0 until the next reset.
- R4: A group write (`wr_en_i`, `wr_grp_i`, `wr_val_i`) made while `acc_ok_o` is 0 is ignored, and `pwup_o` stays 0.
- R5: A write of 1 to a group whose flag is 0 sets `pwup_o[g]` and `busy_o[g]` after that edge. While the group is busy, `coef_clr_o[g]` is 1 and `ready_o[g]` is 0.
- R6: `busy_o[g]` stays 1 until the edge that samples the second `fsync_i` pulse counted after the write edge. A pulse on the write edge itself does not count. `busy_o[g]` then falls and `ready_o[g]` rises.
- R7: Each pass emits exactly 64 cycles with `init_we_o`=1, `init_grp_o`=g and `init_addr_o` counting 0 to 63 in order. On each of those cycles, `init_data_o` = (addr*37 + 0x5A) mod 256.
- R8: A write of 1 to a group whose flag is already 1 starts no pass. No busy flag rises and no init writes occur.
- R9: A write of 0 to a busy group clears `pwup_o[g]`, `busy_o[g]` and `coef_clr_o[g]` after that edge. No further init writes occur for that group.
- R10: When several groups need init writes, the lowest group index gets the write port each cycle. A lower-index group started later therefore pre-empts a higher one, and each group still receives all 64 writes.
- R11: Pulses on `fsync_i` during the lock wait do not change when `acc_ok_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset / power-down request, sampled on clk |
| fsync_i | input | 1 | Frame sync pulse, one cycle per frame |
| wr_en_i | input | 1 | Group control write strobe |
| wr_grp_i | input | 4 | Group index of the write |
| wr_val_i | input | 1 | Power-up flag value written |
| acc_ok_o | output | 1 | Register access granted (lock wait done) |
| rst_bad_o | output | 1 | Last reset pulse was too short |
| out_en_o | output | 1 | Bus and serial output enable, low in power-down |
| pwup_o | output | 16 | Per-group power-up flags |
| busy_o | output | 16 | Per-group initialization in progress |
| ready_o | output | 16 | Per-group channel registers open to the host |
| coef_clr_o | output | 16 | Per-group coefficient memory clear |
| init_we_o | output | 1 | Default-value write strobe |
| init_grp_o | output | 4 | Group targeted by the default write |
| init_addr_o | output | 6 | Register offset within the group window |
| init_data_o | output | 8 | Default value written |

## Verification
A wrong hold or lock count moves the rising edge of `acc_ok_o` off its exact cycle, so the bench measures that cycle directly. A group frame counter that counts wrongly would show within one frame period. `busy_o` would fall one frame early or late, or not at all. A slip in the per-group write counter or the arbiter would appear as soon as the first default write. It shows as a missing, repeated or misordered offset, or a wrong group index, on `init_grp_o`/`init_addr_o`. Lost edge detection on the flag would show as a pass on a repeated write, or as no pass on a fresh one.

// File: rtl/grp_pwr_pkg.sv
package grp_pwr_pkg;

    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_BAD  = 2'd1,
        PS_LOCK = 2'd2,
        PS_RUN  = 2'd3
    } pwr_st_e;

    // default contents of a group register window, computed from the offset
    function automatic logic [7:0] reg_default(input logic [15:0] ofs, input logic [7:0] seed);
        logic [21:0] prod;
        prod = {6'd0, ofs} * 22'd37;
        return prod[7:0] + seed;
    endfunction

endpackage

// File: rtl/rst_lock_ctrl.sv
module rst_lock_ctrl
    import grp_pwr_pkg::*;
#(
    parameter int HOLD_CYC = 100,
    parameter int LOCK_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic acc_ok_o,
    output logic rst_bad_o,
    output logic out_en_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int LW = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        pwr_st_e       st;
        logic [HW-1:0] hold;
        logic [LW-1:0] lock;
    } ctl_t;

    ctl_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (!rst_n) begin
            c_d.st   = PS_DOWN;
            c_d.lock = '0;
            if (c_q.st != PS_DOWN)
                c_d.hold = HW'(1);
            else if (c_q.hold != HW'(HOLD_CYC))
                c_d.hold = c_q.hold + 1'b1;
        end else begin
            case (c_q.st)
                PS_DOWN: begin
                    c_d.lock = '0;
                    c_d.st   = (c_q.hold >= HW'(HOLD_CYC)) ? PS_LOCK : PS_BAD;
                end
                PS_LOCK: begin
                    if (c_q.lock == LW'(LOCK_CYC - 1))
                        c_d.st = PS_RUN;
                    else
                        c_d.lock = c_q.lock + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign acc_ok_o  = (c_q.st == PS_RUN);
    assign rst_bad_o = (c_q.st == PS_BAD);
    assign out_en_o  = (c_q.st != PS_DOWN);

    // R3: an invalid reset never leads to access
    a_r3_bad_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rst_bad_o |=> !acc_ok_o);

    // R2: access only ever opens out of the lock wait
    a_r2_run_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_ok_o) |-> $past(c_q.st == PS_LOCK));

endmodule

// File: rtl/grp_init_slot.sv
module grp_init_slot #(
    parameter int WIN = 64,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit_i,
    input  logic          wr_val_i,
    input  logic          fsync_i,
    input  logic          grant_i,
    output logic          pwup_o,
    output logic          busy_o,
    output logic          need_o,
    output logic [CW-1:0] wcnt_o
);
    typedef struct packed {
        logic          pwup;
        logic          busy;
        logic          fcnt;
        logic [CW-1:0] wcnt;
    } slot_t;

    slot_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!rst_n) begin
            s_d = '0;
        end else begin
            if (s_q.busy) begin
                if (grant_i)
                    s_d.wcnt = s_q.wcnt + 1'b1;
                if (fsync_i) begin
                    if (s_q.fcnt)
                        s_d.busy = 1'b0;
                    else
                        s_d.fcnt = 1'b1;
                end
            end
            if (wr_hit_i) begin
                s_d.pwup = wr_val_i;
                if (wr_val_i && !s_q.pwup) begin
                    s_d.busy = 1'b1;
                    s_d.fcnt = 1'b0;
                    s_d.wcnt = '0;
                end else if (!wr_val_i) begin
                    s_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pwup_o = s_q.pwup;
    assign busy_o = s_q.busy;
    assign need_o = s_q.busy && (s_q.wcnt < CW'(WIN));
    assign wcnt_o = s_q.wcnt;

    // R9: a group is never busy while powered down
    a_r9_busy_needs_pwup: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.pwup);

    // R8: a pass starts only on a 0-to-1 change of the flag
    a_r8_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $rose(s_q.pwup));

    // R6: a pass that is not aborted ends only on a frame pulse
    a_r6_end_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.busy) && s_q.pwup) |-> $past(fsync_i));

    // R7: the write counter never runs past the window
    a_r7_win_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wcnt <= CW'(WIN));

endmodule

// File: rtl/init_wr_arb.sv
module init_wr_arb #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  need_i,
    output logic [N-1:0]  grant_o,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        valid_o = |need_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (need_i[i])
                idx_o = IW'(i);
        end
        if (valid_o)
            grant_o[idx_o] = 1'b1;
    end
endmodule

// File: rtl/grp_pwr_seq.sv
module grp_pwr_seq
    import grp_pwr_pkg::*;
#(
    parameter int          NUM_GRP  = 16,
    parameter int          WIN      = 64,
    parameter int          HOLD_CYC = 100,
    parameter int          LOCK_CYC = 500,
    parameter logic [7:0]  SEED     = 8'h5A,
    localparam int         GW       = $clog2(NUM_GRP),
    localparam int         AW       = $clog2(WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync_i,
    input  logic               wr_en_i,
    input  logic [GW-1:0]      wr_grp_i,
    input  logic               wr_val_i,
    output logic               acc_ok_o,
    output logic               rst_bad_o,
    output logic               out_en_o,
    output logic [NUM_GRP-1:0] pwup_o,
    output logic [NUM_GRP-1:0] busy_o,
    output logic [NUM_GRP-1:0] ready_o,
    output logic [NUM_GRP-1:0] coef_clr_o,
    output logic               init_we_o,
    output logic [GW-1:0]      init_grp_o,
    output logic [AW-1:0]      init_addr_o,
    output logic [7:0]         init_data_o
);
    localparam int CW = $clog2(WIN + 1);

    logic [NUM_GRP-1:0] need, grant;
    logic [CW-1:0]      wcnt [NUM_GRP];
    logic [GW-1:0]      sel;

    rst_lock_ctrl #(.HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_ok_o  (acc_ok_o),
        .rst_bad_o (rst_bad_o),
        .out_en_o  (out_en_o)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
        logic hit;
        assign hit = wr_en_i && acc_ok_o && (wr_grp_i == GW'(g));
        grp_init_slot #(.WIN(WIN)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit_i (hit),
            .wr_val_i (wr_val_i),
            .fsync_i  (fsync_i),
            .grant_i  (grant[g]),
            .pwup_o   (pwup_o[g]),
            .busy_o   (busy_o[g]),
            .need_o   (need[g]),
            .wcnt_o   (wcnt[g])
        );
    end

    init_wr_arb #(.N(NUM_GRP)) u_arb (
        .need_i  (need),
        .grant_o (grant),
        .valid_o (init_we_o),
        .idx_o   (sel)
    );

    assign init_grp_o  = sel;
    assign init_addr_o = wcnt[sel][AW-1:0];
    assign init_data_o = reg_default(16'(init_addr_o), SEED);
    assign coef_clr_o  = busy_o;
    assign ready_o     = pwup_o & ~busy_o & {NUM_GRP{acc_ok_o}};

    // R4: no group is powered while access is refused
    a_r4_no_pwup_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok_o |-> (pwup_o == '0));

    // R7: default writes happen only with access granted
    a_r7_init_only_run: assert property (@(posedge clk) disable iff (!rst_n)
        init_we_o |-> acc_ok_o);

    // R10: at most one group owns the write port
    a_r10_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: tb/grp_pwr_seq_tb.sv
module grp_pwr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 100;
    localparam int LOCK = 500;
    localparam int FRM  = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_grp = '0;
    logic        wr_val = 1'b0;
    logic        fsync;
    logic        acc_ok, rst_bad, out_en, init_we;
    logic [15:0] pwup, busy, ready, coef_clr;
    logic [3:0]  init_grp;
    logic [5:0]  init_addr;
    logic [7:0]  init_data;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign fsync = ((cyc % FRM) == FRM - 1);

    grp_pwr_seq dut_i (
        .clk (clk), .rst_n (rst_n), .fsync_i (fsync),
        .wr_en_i (wr_en), .wr_grp_i (wr_grp), .wr_val_i (wr_val),
        .acc_ok_o (acc_ok), .rst_bad_o (rst_bad), .out_en_o (out_en),
        .pwup_o (pwup), .busy_o (busy), .ready_o (ready), .coef_clr_o (coef_clr),
        .init_we_o (init_we), .init_grp_o (init_grp),
        .init_addr_o (init_addr), .init_data_o (init_data)
    );

    function automatic logic [7:0] exp_def(input int a);
        return 8'((a * 37 + 'h5A) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // caller stands at a negedge; returns just after the write edge
    task automatic do_write(input int g, input bit v);
        wr_en  = 1'b1;
        wr_grp = 4'(g);
        wr_val = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic t_reset_low(input int len);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (len) @(negedge clk);
        chk(out_en == 0 && acc_ok == 0 && init_we == 0, "R1", "enables", out_en, 0);
        chk(pwup == 0 && busy == 0, "R1", "pwup|busy", pwup | busy, 0);
        chk(ready == 0 && coef_clr == 0, "R1", "ready|clr", ready | coef_clr, 0);
    endtask

    task automatic t_short_reset();
        t_reset_low(HOLD / 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rst_bad == 1, "R3", "rst_bad", rst_bad, 1);
        wr_en = 1'b1; wr_grp = 4'd1; wr_val = 1'b1;
        repeat (LOCK + 20) @(negedge clk);
        wr_en = 1'b0;
        chk(acc_ok == 0, "R3", "acc_ok after short", acc_ok, 0);
        chk(pwup == 0, "R4", "pwup after refused write", pwup, 0);
    endtask

    task automatic t_bringup();
        t_reset_low(HOLD + 5);
        rst_n = 1'b1;
        wr_en = 1'b1; wr_grp = 4'd0; wr_val = 1'b1;
        for (int k = 1; k <= LOCK + 1; k++) begin
            @(negedge clk);
            if (k == LOCK) begin
                chk(acc_ok == 0, "R2", "acc_ok before end of wait", acc_ok, 0);
                wr_en = 1'b0;
            end
            if (k == LOCK + 1) begin
                // R11: fsync pulsed all through the wait
                chk(acc_ok == 1, "R11", "acc_ok at end of wait", acc_ok, 1);
                chk(rst_bad == 0, "R2", "rst_bad", rst_bad, 0);
                chk(pwup == 0, "R4", "pwup after lock-wait write", pwup, 0);
            end
        end
    endtask

    task automatic t_init(input int g);
        int n = 0, wc = 0, errs = 0, early = 0;
        do_write(g, 1'b1);
        @(negedge clk);
        chk(busy[g] == 1 && pwup[g] == 1, "R5", "busy after start", busy[g], 1);
        chk(coef_clr[g] == 1, "R5", "coef_clr", coef_clr[g], 1);
        chk(ready[g] == 0, "R5", "ready while busy", ready[g], 0);
        for (int it = 0; it < 4 * FRM; it++) begin
            if (init_we) begin
                if (init_grp != 4'(g) || init_addr != 6'(wc) || init_data != exp_def(wc))
                    errs++;
                wc++;
            end
            if (n == 2) break;
            if (busy[g] !== 1'b1) early++;
            if (fsync) n++;
            @(negedge clk);
        end
        chk(n == 2 && busy[g] == 0, "R6", "busy after 2 frames", busy[g], 0);
        chk(early == 0, "R6", "early busy drop", early, 0);
        chk(ready[g] == 1, "R6", "ready after pass", ready[g], 1);
        chk(wc == 64, "R7", "write count", wc, 64);
        chk(errs == 0, "R7", "write contents", errs, 0);
    endtask

    task automatic t_rewrite(input int g);
        int seen = 0;
        do_write(g, 1'b1);
        repeat (20) begin
            @(negedge clk);
            if (busy[g] || init_we) seen++;
        end
        chk(seen == 0, "R8", "restart on repeated 1", seen, 0);
        chk(ready[g] == 1, "R8", "ready kept", ready[g], 1);
    endtask

    task automatic t_abort(input int g);
        int seen = 0;
        do_write(g, 1'b1);
        repeat (10) @(negedge clk);
        chk(busy[g] == 1, "R9", "busy before abort", busy[g], 1);
        do_write(g, 1'b0);
        @(negedge clk);
        chk(busy[g] == 0 && pwup[g] == 0, "R9", "state after abort", {busy[g], pwup[g]}, 0);
        chk(coef_clr[g] == 0, "R9", "coef_clr after abort", coef_clr[g], 0);
        repeat (2 * FRM) begin
            @(negedge clk);
            if (busy[g] || (init_we && init_grp == 4'(g))) seen++;
        end
        chk(seen == 0, "R9", "activity after abort", seen, 0);
    endtask

    task automatic t_multi(input int hi, input int lo);
        int gq[256];
        int aq[256];
        int dq[256];
        int cnt = 0, errs = 0;
        do_write(hi, 1'b1);
        @(negedge clk);
        if (init_we) begin gq[cnt] = init_grp; aq[cnt] = init_addr; dq[cnt] = init_data; cnt++; end
        do_write(lo, 1'b1);
        for (int it = 0; it < 200; it++) begin
            @(negedge clk);
            if (init_we && cnt < 256) begin
                gq[cnt] = init_grp; aq[cnt] = init_addr; dq[cnt] = init_data; cnt++;
            end
        end
        chk(cnt == 128, "R10", "total writes", cnt, 128);
        for (int i = 0; i < 128 && i < cnt; i++) begin
            int eg, ea;
            if (i == 0) begin eg = hi; ea = 0; end
            else if (i <= 64) begin eg = lo; ea = i - 1; end
            else begin eg = hi; ea = i - 64; end
            if (gq[i] != eg || aq[i] != ea || dq[i] != int'(exp_def(ea))) errs++;
        end
        chk(errs == 0, "R10", "pre-emption order", errs, 0);
        for (int it = 0; it < 4 * FRM; it++) begin
            if (busy == 0) break;
            @(negedge clk);
        end
        chk(ready[hi] == 1 && ready[lo] == 1, "R10", "both ready", {ready[hi], ready[lo]}, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_short_reset();
        t_bringup();
        t_init(5);
        t_rewrite(5);
        t_abort(4);
        t_multi(7, 3);
        t_reset_low(HOLD + 5);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule